// File: doc/BRIEF.md
# RS-485 Transmit Direction Controller

This block generates the direction-control output for a half-duplex RS-485 transceiver. It watches the status of a UART transmitter. The output is driven active while the transmit queue holds data or the shift register is putting a character on the line. When the last stop bit of the last queued character has gone out and the queue is empty, the output stays active for a programmable number of bit times, and is then released. This turnaround gap gives the far end time before the local driver lets go of the bus.

The hold length is an 8-bit value in bit times, from 0 to 255. It counts only on the one-cycle baud enable, which pulses once per bit time. The value is captured when a hold interval begins, so software may rewrite it at any time. If new data is queued during a hold, the hold is cancelled and the output stays active with no gap. A polarity input chooses whether the active level is low or high.

Top module: `rs485_dir_ctl`

## Requirements
- R1: After reset the direction output is at its inactive level for the current polarity (1 when `cfg_invert`=0, 0 when `cfg_invert`=1), and no hold interval is running.
- R2: In the clock cycle after any cycle in which `fifo_empty`=0 or `shift_busy`=1, the output is at its active level.
- R3: A cycle with `stop_done`=1 and `fifo_empty`=1 starts a hold of D=`cfg_delay` bit times, with D>0. The output stays active through the cycle in which the (D-1)th later `baud_tick` is registered. It turns inactive in the cycle after the D-th `baud_tick` that follows the start cycle. A tick in the start cycle itself does not count.
- R4: With D=0, the output turns inactive in the clock cycle right after the `stop_done` strobe.
- R5: During a hold, clock cycles without `baud_tick` neither shorten nor end the hold.
- R6: If `fifo_empty` falls during a hold, the hold is cancelled and the output stays active with no inactive cycle. The next hold then runs its full length.
- R7: `cfg_delay` is sampled only when a hold starts. Changing it during a hold does not alter that hold.
- R8: The active level is 0 when `cfg_invert`=0 and 1 when `cfg_invert`=1. The inactive level is the complement.
- R9: A `stop_done` strobe while `fifo_empty`=0 (back-to-back characters) starts no hold. The output stays active across later baud ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle enable, once per bit time |
| fifo_empty | input | 1 | Transmit queue holds no data |
| shift_busy | input | 1 | Shift register is sending a character |
| stop_done | input | 1 | Strobe: a stop bit has just completed |
| cfg_delay | input | DLY_W (8) | Hold length in bit times |
| cfg_invert | input | 1 | Selects an active-high output |
| dir_out | output | 1 | Transceiver direction control |

## Verification
The bench counts baud ticks from each final stop bit to the release. It uses lengths of 0, 1 and 255, both polarities, and several spacings between ticks. A design off by one tick, or one that counted system clocks, would release a tick early or late, or release during the idle cycles between ticks. Directed cases queue data during a hold, rewrite the delay during a hold, and send back-to-back characters. A design that glitched inactive, used the new delay at once, or started a hold on a stop bit with more data still queued would show a wrong level in a specific sampled cycle. Reset during a hold must return the output to the inactive level of the selected polarity.

// File: rtl/rs485_dir_ctl.sv
module rs485_dir_ctl #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             baud_tick,
  input  logic             fifo_empty,
  input  logic             shift_busy,
  input  logic             stop_done,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic             cfg_invert,
  output logic             dir_out
);
  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  logic             en_q;
  logic             hold_q;
  logic [DLY_W-1:0] cnt_q;

  wire start   = stop_done & fifo_empty;
  wire last    = (cnt_q == ONE);
  wire nonzero = (cfg_delay != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      hold_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!fifo_empty) begin
      en_q   <= 1'b1;
      hold_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      en_q   <= nonzero;
      hold_q <= nonzero;
      cnt_q  <= cfg_delay;
    end else if (hold_q) begin
      if (baud_tick) begin
        cnt_q <= cnt_q - ONE;
        if (last) begin
          hold_q <= 1'b0;
          en_q   <= 1'b0;
        end
      end
    end else begin
      en_q <= shift_busy;
    end
  end

  assign dir_out = ~(en_q ^ cfg_invert);

  p_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_empty |=> en_q);

  p_hold_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> en_q);

  p_hold_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q && fifo_empty && !stop_done |=> hold_q || !en_q);

  p_zero_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start && !nonzero |=> !en_q && !hold_q);

  p_no_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q && fifo_empty && !stop_done && !baud_tick |=> hold_q && $stable(cnt_q));

  p_cancel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q && !fifo_empty |=> en_q && !hold_q);

  p_cnt_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> cnt_q != '0);
endmodule

// File: tb/rs485_dir_ctl_bench.sv
`timescale 1ns/1ps
module rs485_dir_ctl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       fifo_empty = 1'b1;
  logic       shift_busy = 1'b0;
  logic       stop_done = 1'b0;
  logic [7:0] cfg_delay = 8'd0;
  logic       cfg_invert = 1'b0;
  logic       dir_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  rs485_dir_ctl #(.DLY_W(8)) u_rs485_dir_ctl (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .fifo_empty(fifo_empty),
    .shift_busy(shift_busy), .stop_done(stop_done), .cfg_delay(cfg_delay),
    .cfg_invert(cfg_invert), .dir_out(dir_out)
  );

  always #2.5 clk = ~clk;

  // {delay, invert, idle cycles between ticks}
  localparam logic [12:0] VEC [0:7] = '{
    {8'd0,   1'b0, 4'd2},
    {8'd0,   1'b1, 4'd0},
    {8'd1,   1'b0, 4'd0},
    {8'd1,   1'b1, 4'd3},
    {8'd4,   1'b0, 4'd15},
    {8'd7,   1'b1, 4'd1},
    {8'd255, 1'b0, 4'd0},
    {8'd255, 1'b1, 4'd2}
  };

  function automatic logic lvl(input logic active, input logic inv);
    return inv ? active : ~active;
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic exp);
    checks++;
    if (dir_out !== exp) begin
      errors++;
      $display("FAIL %s dir_out=%b expected=%b at %0t", req, dir_out, exp, $time);
    end
  endtask

  task automatic send_char(input logic inv);
    fifo_empty = 1'b0; step(); chk("R2", lvl(1'b1, inv));
    fifo_empty = 1'b1; shift_busy = 1'b1; step(); chk("R2", lvl(1'b1, inv));
    step(); chk("R2", lvl(1'b1, inv));
  endtask

  task automatic last_stop(input logic [7:0] d, input logic inv);
    stop_done = 1'b1; baud_tick = 1'b1; shift_busy = 1'b0; step();
    stop_done = 1'b0; baud_tick = 1'b0;
    chk(d == 0 ? "R4" : "R3", lvl(d != 0, inv));
  endtask

  task automatic count_ticks(input int n, input int total, input int gap, input logic inv);
    for (int k = 1; k <= n; k++) begin
      for (int g = 0; g < gap; g++) begin step(); chk("R5", lvl(1'b1, inv)); end
      baud_tick = 1'b1; step(); baud_tick = 1'b0;
      chk("R3", lvl(k < total, inv));
    end
  endtask

  task automatic run_hold(input logic [7:0] d, input logic inv, input int gap);
    cfg_delay = d; cfg_invert = inv;
    step(); chk("R8", lvl(1'b0, inv));
    send_char(inv);
    last_stop(d, inv);
    count_ticks(d, d, gap, inv);
    baud_tick = 1'b1; step(); baud_tick = 1'b0; step();
    chk("R3", lvl(1'b0, inv));
  endtask

  initial begin
    while (cycles < 150000) begin @(posedge clk); cycles++; end
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(); step();
    chk("R1", 1'b1);
    cfg_invert = 1'b1; #1; chk("R1", 1'b0);
    cfg_invert = 1'b0;
    rst_n = 1'b1; step(); chk("R1", 1'b1);

    for (int i = 0; i < 8; i++)
      run_hold(VEC[i][12:5], VEC[i][4], int'(VEC[i][3:0]));

    // R6: new data during hold cancels, next hold runs full length
    cfg_delay = 8'd5; cfg_invert = 1'b0;
    send_char(1'b0); last_stop(8'd5, 1'b0);
    count_ticks(2, 5, 1, 1'b0);
    fifo_empty = 1'b0; baud_tick = 1'b1; step(); baud_tick = 1'b0;
    chk("R6", 1'b0);
    for (int j = 0; j < 6; j++) begin
      baud_tick = 1'b1; step(); baud_tick = 1'b0; chk("R6", 1'b0);
    end
    fifo_empty = 1'b1; shift_busy = 1'b1; step(); chk("R6", 1'b0);
    last_stop(8'd5, 1'b0);
    count_ticks(5, 5, 0, 1'b0);

    // R7: delay rewritten mid-hold is ignored
    cfg_delay = 8'd6; cfg_invert = 1'b1;
    send_char(1'b1); last_stop(8'd6, 1'b1);
    count_ticks(1, 6, 0, 1'b1);
    cfg_delay = 8'd1;
    count_ticks(5, 5, 0, 1'b1);
    chk("R7", 1'b0);

    // R9: stop strobe with more data queued starts no hold
    cfg_delay = 8'd1; cfg_invert = 1'b0;
    send_char(1'b0);
    fifo_empty = 1'b0; stop_done = 1'b1; baud_tick = 1'b1; step();
    stop_done = 1'b0; baud_tick = 1'b0; chk("R9", 1'b0);
    fifo_empty = 1'b1;
    for (int j = 0; j < 4; j++) begin
      baud_tick = 1'b1; step(); baud_tick = 1'b0; chk("R9", 1'b0);
    end
    last_stop(8'd1, 1'b0);
    count_ticks(1, 1, 0, 1'b0);

    // R1: reset in the middle of a hold
    cfg_delay = 8'd9; cfg_invert = 1'b1;
    send_char(1'b1); last_stop(8'd9, 1'b1);
    rst_n = 1'b0; step(); chk("R1", 1'b0);
    rst_n = 1'b1; step(); chk("R1", 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule